// File: doc/BRIEF.md
# Transactional Sharer Notifier for a Coherence Directory

This directory-side unit tracks, for every line it covers, which cores have touched that line inside a transaction. One bit per core records each core. A core does not ask for shared or exclusive ownership. It sends a single mark request. The unit answers with an acknowledgement that tells the requester how many other cores already hold the line. It then sends one accessor notice to each of those cores, naming the requester, the line and whether the access was a read or a write. Each receiving core uses that notice to update its own conflict lists. The unit does not grant ownership and does not invalidate anyone.

When a transaction commits a write, a commit request replaces the line's sharer set with the committing core alone. Requests for different lines use separate sharer vectors, so work on disjoint lines never interferes. Notices leave one per cycle. The request port stalls until every notice for the current mark has been sent, so a requester can rely on the count in its acknowledgement.

Top module: `txdir_notifier`

## Requirements
- R1: While reset is asserted and after it is released, no acknowledgement and no notice is presented, and every line's sharer set is empty.
- R2: A mark accepted at a clock edge (req_valid and req_ready high, req_commit low) produces ack_valid for exactly the following cycle, carrying the requester's core number and line index.
- R3: The acknowledgement count equals the number of cores in the line's sharer set other than the requester. A requester that is already a sharer is not counted.
- R4: If a mark finds no other sharer, its count is 0, no notice follows, and req_ready stays high.
- R5: Each other sharer receives exactly one notice, carrying its own number as destination, the requester's number as source, the line index and the request's read/write flag (1 = write).
- R6: Notices come one per cycle in strictly ascending destination order. The first notice appears in the same cycle as the acknowledgement.
- R7: A requester never receives a notice about its own mark.
- R8: req_ready is low while any notice of the current mark is still pending. A request held during that time is not accepted until req_ready returns high.
- R9: After a mark, the requester belongs to the line's sharer set.
- R10: A commit (req_commit high) leaves only the committer in the line's sharer set. It produces no acknowledgement and no notice.
- R11: A mark or commit on one line leaves the sharer sets of all other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_commit | input | 1 | 1 = commit write, 0 = mark |
| req_write | input | 1 | Read/write flag of a mark (1 = write) |
| req_core | input | 5 | Requesting core number |
| req_line | input | 4 | Tracked line index |
| ack_valid | output | 1 | Acknowledgement present |
| ack_core | output | 5 | Core the acknowledgement goes to |
| ack_line | output | 4 | Line acknowledged |
| ack_count | output | 6 | Number of other sharers |
| note_valid | output | 1 | Accessor notice present |
| note_dest | output | 5 | Core receiving the notice |
| note_src | output | 5 | Core that made the access |
| note_line | output | 4 | Line accessed |
| note_write | output | 1 | Access was a write |

## Verification
The hardest case to reach from the ports is a full line, where the acknowledgement reports every other core and a burst of the longest length streams out while further requests wait. The stimulus builds this by having all cores mark one line in order, so each new core sees a count one higher than the last. A repeat mark from core 0 then produces the longest burst while a held request waits at the port. Contention with commits mixed in comes from random requests confined to a few lines, checked against a behavioural model every cycle.

// File: rtl/txdir_pkg.sv
package txdir_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_MARK   = 2'd1,
    OP_COMMIT = 2'd2
  } txdir_op_e;
endpackage

// File: rtl/txdir_rst_sync.sv
module txdir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/txdir_sharer_store.sv
module txdir_sharer_store #(
  parameter int NUM_CORES = 32,
  parameter int NUM_LINES = 16,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINE_W-1:0]    rd_line,
  output logic [NUM_CORES-1:0] rd_vec,
  input  logic                 wr_en,
  input  logic [LINE_W-1:0]    wr_line,
  input  logic [NUM_CORES-1:0] wr_vec
);
  logic [NUM_CORES-1:0] vec_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic load_en;
    assign load_en = wr_en && (wr_line == LINE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[g] <= '0;
      end else if (load_en) begin
        vec_q[g] <= wr_vec;
      end
    end
  end

  assign rd_vec = vec_q[rd_line];
endmodule

// File: rtl/txdir_ones.sv
module txdir_ones #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/txdir_lowest_pick.sv
module txdir_lowest_pick #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/txdir_notifier.sv
module txdir_notifier
  import txdir_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int CNT_W  = $clog2(NUM_CORES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_commit,
  input  logic              req_write,
  input  logic [CORE_W-1:0] req_core,
  input  logic [LINE_W-1:0] req_line,
  output logic              ack_valid,
  output logic [CORE_W-1:0] ack_core,
  output logic [LINE_W-1:0] ack_line,
  output logic [CNT_W-1:0]  ack_count,
  output logic              note_valid,
  output logic [CORE_W-1:0] note_dest,
  output logic [CORE_W-1:0] note_src,
  output logic [LINE_W-1:0] note_line,
  output logic              note_write
);
  logic rst_q_n;

  txdir_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q_n)
  );

  // Request decode
  txdir_op_e            op;
  logic [NUM_CORES-1:0] req_bit;
  logic [NUM_CORES-1:0] cur_vec;
  logic [NUM_CORES-1:0] other_vec;
  logic [NUM_CORES-1:0] new_vec;
  logic [CNT_W-1:0]     other_cnt;

  // Notice sequencing state
  logic [NUM_CORES-1:0] pend_q, pend_d;
  logic                 pick_found;
  logic [CORE_W-1:0]    pick_idx;

  // Acknowledge and notice registers
  logic              ack_v_q, ack_v_d;
  logic [CORE_W-1:0] ack_core_q;
  logic [LINE_W-1:0] ack_line_q;
  logic [CNT_W-1:0]  ack_cnt_q;
  logic [CORE_W-1:0] src_q;
  logic [LINE_W-1:0] line_q;
  logic              wr_q;
  logic              mark_en;

  assign req_ready = rst_q_n && (pend_q == '0);

  always_comb begin
    op = OP_IDLE;
    if (req_valid && req_ready) begin
      op = req_commit ? OP_COMMIT : OP_MARK;
    end
  end

  assign req_bit   = NUM_CORES'(1) << req_core;
  assign other_vec = cur_vec & ~req_bit;
  assign new_vec   = (op == OP_COMMIT) ? req_bit : (cur_vec | req_bit);
  assign mark_en   = (op == OP_MARK);

  txdir_sharer_store #(
    .NUM_CORES (NUM_CORES),
    .NUM_LINES (NUM_LINES)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .rd_line (req_line),
    .rd_vec  (cur_vec),
    .wr_en   (op != OP_IDLE),
    .wr_line (req_line),
    .wr_vec  (new_vec)
  );

  txdir_ones #(.W(NUM_CORES)) u_ones (
    .vec (other_vec),
    .cnt (other_cnt)
  );

  txdir_lowest_pick #(.W(NUM_CORES)) u_pick (
    .vec   (pend_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // Next-state
  always_comb begin
    pend_d  = pend_q;
    ack_v_d = 1'b0;
    if (mark_en) begin
      pend_d  = other_vec;
      ack_v_d = 1'b1;
    end else if (pick_found) begin
      pend_d = pend_q & (pend_q - NUM_CORES'(1));
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pend_q  <= '0;
      ack_v_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      ack_v_q <= ack_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ack_core_q <= '0;
      ack_line_q <= '0;
      ack_cnt_q  <= '0;
      src_q      <= '0;
      line_q     <= '0;
      wr_q       <= 1'b0;
    end else if (mark_en) begin
      ack_core_q <= req_core;
      ack_line_q <= req_line;
      ack_cnt_q  <= other_cnt;
      src_q      <= req_core;
      line_q     <= req_line;
      wr_q       <= req_write;
    end
  end

  assign ack_valid  = ack_v_q;
  assign ack_core   = ack_core_q;
  assign ack_line   = ack_line_q;
  assign ack_count  = ack_cnt_q;
  assign note_valid = pick_found;
  assign note_dest  = pick_idx;
  assign note_src   = src_q;
  assign note_line  = line_q;
  assign note_write = wr_q;
endmodule

// File: rtl/txdir_notifier_chk.sv
module txdir_notifier_chk #(
  parameter int NUM_CORES = 32,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int CNT_W  = $clog2(NUM_CORES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_commit,
  input logic              ack_valid,
  input logic [CNT_W-1:0]  ack_count,
  input logic              note_valid,
  input logic [CORE_W-1:0] note_dest,
  input logic [CORE_W-1:0] note_src,
  input logic [LINE_W-1:0] note_line
);
  // Notices still owed for the current mark
  logic [CNT_W-1:0] owed_q;
  logic [CNT_W-1:0] owed_now;

  assign owed_now = ack_valid ? ack_count : owed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else begin
      owed_q <= owed_now - CNT_W'(note_valid);
    end
  end

  p_ack_after_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_commit |=> ack_valid);

  p_commit_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_commit |=> !ack_valid && !note_valid);

  p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (int'(ack_count) < NUM_CORES));

  p_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && (ack_count == '0) |-> !note_valid && req_ready);

  p_first_note_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && (ack_count != '0) |-> note_valid);

  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && !ack_valid |-> $past(note_valid) && (note_dest > $past(note_dest)));

  p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && !ack_valid |-> $stable(note_src) && $stable(note_line));

  p_note_owed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> owed_now != '0);

  p_none_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !note_valid |-> owed_now == '0);

  p_no_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> note_dest != note_src);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> !req_ready);
endmodule

bind txdir_notifier txdir_notifier_chk #(
  .NUM_CORES (NUM_CORES),
  .NUM_LINES (NUM_LINES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_commit (req_commit),
  .ack_valid  (ack_valid),
  .ack_count  (ack_count),
  .note_valid (note_valid),
  .note_dest  (note_dest),
  .note_src   (note_src),
  .note_line  (note_line)
);

// File: tb/txdir_notifier_tb.sv
module txdir_notifier_tb;
  localparam int NC = 32;
  localparam int NL = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_commit = 1'b0;
  logic       req_write = 1'b0;
  logic [4:0] req_core = '0;
  logic [3:0] req_line = '0;
  logic       req_ready, ack_valid, note_valid, note_write;
  logic [4:0] ack_core, note_dest, note_src;
  logic [3:0] ack_line, note_line;
  logic [5:0] ack_count;

  always #2 clk = ~clk;

  txdir_notifier u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_commit (req_commit), .req_write (req_write), .req_core (req_core),
    .req_line (req_line), .ack_valid (ack_valid), .ack_core (ack_core),
    .ack_line (ack_line), .ack_count (ack_count), .note_valid (note_valid),
    .note_dest (note_dest), .note_src (note_src), .note_line (note_line),
    .note_write (note_write)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit [NC-1:0] m_sh [NL];
  int          q_dest[$];
  int          rcnt = 0;
  bit          e_ack = 0;
  int          e_core = 0, e_line = 0, e_cnt = 0, e_src = 0, e_nline = 0;
  bit          e_wr = 0;
  bit          accepted = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) m_sh[i] = '0;
      q_dest.delete();
      rcnt = 0; e_ack = 0; accepted = 0;
    end else begin
      bit pre_rdy;
      bit [NC-1:0] mine, others;
      pre_rdy = (rcnt >= 2) && (q_dest.size() == 0);
      if (rcnt < 5) rcnt++;
      if (q_dest.size() > 0) void'(q_dest.pop_front());
      e_ack = 0;
      accepted = 0;
      if (req_valid && pre_rdy) begin
        accepted = 1;
        mine = NC'(1) << req_core;
        if (req_commit) begin
          m_sh[req_line] = mine;
        end else begin
          others = m_sh[req_line] & ~mine;
          e_ack = 1; e_core = req_core; e_line = req_line;
          e_cnt = $countones(others);
          e_src = req_core; e_nline = req_line; e_wr = req_write;
          for (int c = 0; c < NC; c++) if (others[c]) q_dest.push_back(c);
          m_sh[req_line] = m_sh[req_line] | mine;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == ((rcnt >= 2) && (q_dest.size() == 0)), "R8", "req_ready",
          req_ready, (rcnt >= 2) && (q_dest.size() == 0));
      chk(ack_valid == e_ack, "R2", "ack_valid", ack_valid, e_ack);
      if (e_ack && ack_valid) begin
        chk(ack_core == e_core, "R2", "ack_core", ack_core, e_core);
        chk(ack_line == e_line, "R2", "ack_line", ack_line, e_line);
        chk(ack_count == e_cnt, "R3", "ack_count", ack_count, e_cnt);
      end
      chk(note_valid == (q_dest.size() > 0), "R5", "note_valid", note_valid, q_dest.size() > 0);
      if (note_valid && q_dest.size() > 0) begin
        chk(note_dest == q_dest[0], "R6", "note_dest", note_dest, q_dest[0]);
        chk(note_src == e_src, "R5", "note_src", note_src, e_src);
        chk(note_line == e_nline, "R5", "note_line", note_line, e_nline);
        chk(note_write == e_wr, "R5", "note_write", note_write, e_wr);
        chk(note_dest != note_src, "R7", "self notice", note_dest, -1);
      end
    end
  end

  int got_cnt;

  task automatic send(input int core, input int line, input bit wr, input bit commit);
    req_core = 5'(core); req_line = 4'(line); req_write = wr; req_commit = commit;
    req_valid = 1'b1;
    do @(negedge clk); while (!accepted);
    got_cnt = ack_count;
    req_valid = 1'b0;
  endtask

  bit done = 0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ack_valid == 0, "R1", "ack in reset", ack_valid, 0);
    chk(note_valid == 0, "R1", "note in reset", note_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack_valid == 0 && note_valid == 0, "R1", "idle after reset", ack_valid, 0);

    send(3, 2, 0, 0);
    chk(got_cnt == 0, "R4", "empty line count", got_cnt, 0);
    chk(note_valid == 0 && req_ready == 1, "R4", "no stall", note_valid, 0);
    send(5, 2, 1, 0);
    chk(got_cnt == 1, "R9", "earlier marker counted", got_cnt, 1);
    @(negedge clk);
    send(3, 2, 0, 0);
    chk(got_cnt == 1, "R3", "self not counted", got_cnt, 1);
    @(negedge clk);
    send(7, 4, 1, 0);
    chk(got_cnt == 0, "R11", "other line untouched", got_cnt, 0);
    send(9, 2, 1, 1);
    send(1, 2, 0, 0);
    chk(got_cnt == 1, "R10", "commit leaves committer only", got_cnt, 1);
    @(negedge clk);
    send(8, 4, 0, 0);
    chk(got_cnt == 1, "R11", "line 4 after line 2 commit", got_cnt, 1);
    @(negedge clk);

    for (int k = 0; k < NC; k++) begin
      send(k, 6, k[0], 0);
      chk(got_cnt == k, "R3", "fill count", got_cnt, k);
      while (!req_ready) @(negedge clk);
    end
    send(0, 6, 1, 0);
    chk(got_cnt == NC - 1, "R3", "full line count", got_cnt, NC - 1);
    // held request while the long burst drains
    send(2, 6, 0, 1);
    send(4, 6, 0, 0);
    chk(got_cnt == 1, "R10", "commit after burst", got_cnt, 1);

    for (int n = 0; n < 400; n++) begin
      send($urandom_range(NC - 1), $urandom_range(3), 1'($urandom_range(1)),
           ($urandom_range(7) == 0));
    end
    repeat (40) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule